// File: doc/BRIEF.md
# Multiplexed ADC Frame Sequencer

This block generates the repeating frame timing for a sampling front end that shares one converter among several inputs through a multiplexer. A divider turns the fast system clock into a slow conversion tick. Each frame opens with one settle tick, during which a frame sync signal is high. Conversions follow, one per multiplexer input, and each conversion lasts two or three slow ticks depending on a filter-length select. When a conversion completes, a one-cycle strobe fires that carries the index of the input just converted. At the same moment the multiplexer index moves on to the next input.

Strobes taken from the edges of the sync signal drive the downstream blocks. When sync falls, a compute-pass start fires. When sync rises, two serial stream starts fire together, and a real-time stream busy window opens for a fixed number of fast cycles. A transfer marker fires with every M-th compute-pass start, where M is the product of two configuration fields. The frame configuration is captured only at reset and at a frame boundary, so a running frame never changes shape part way through.

Top module: `mux_frame_seq`

## Requirements
- R1: One slow tick lasts exactly TICK_DIV fast cycles (default 150). `slow_tick_o` is high in the first fast cycle of every slow tick except the tick that begins at reset.
- R2: A frame lasts (1 + C·N) slow ticks, where C = 2 when `cfg_flen_i`=0 and C = 3 when it is 1, and N is the number of multiplexer states. `frame_sync_o` is high for exactly the first slow tick of each frame, which is the settle tick, and low for the rest of the frame.
- R3: `conv_done_o` pulses for one fast cycle in the first cycle after each conversion ends. `conv_idx_o` then gives the index of that conversion. With C=3 the pulses come 450, 900, 1350 and 1800 fast cycles after the settle tick ends. The last pulse of a frame coincides with the first cycle of the next frame.
- R4: `mux_state_o` is 0 during the settle tick and equals i during conversion i. It advances on the cycle of the done pulse and wraps to 0 after the last state.
- R5: `cfg_nstates_i`, `cfg_flen_i`, `cfg_presamps_i` and `cfg_sumcyc_i` are sampled only in the reset cycle and at the edge that begins a new frame. A mid-frame change first affects the next frame. A state count of 0 acts as 1, and a count above MAX_STATES acts as MAX_STATES.
- R6: `pass_start_o` pulses for one cycle in the first fast cycle after the settle tick, which is the cycle in which `frame_sync_o` falls.
- R7: `rtm_start_o` and `ssi_start_o` pulse together in the first cycle of every frame in which `frame_sync_o` rises, so not in the frame that begins at reset.
- R8: `rtm_busy_o` is high for exactly RTM_LEN fast cycles (default 140), beginning with the cycle of `rtm_start_o`. It is never high together with `pass_start_o`.
- R9: `xfer_mark_o` pulses together with every M-th `pass_start_o` after reset, where M = presamps × sumcyc as sampled for that frame. M = 0 acts as 1.
- R10: After reset, `frame_sync_o` is 1, `mux_state_o` is 0 and every strobe and busy output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nstates_i | input | IDX_W+1 | Requested number of multiplexer states |
| cfg_flen_i | input | 1 | Filter-length select: 0 gives 2 ticks per conversion, 1 gives 3 |
| cfg_presamps_i | input | PS_W | First factor of the transfer period |
| cfg_sumcyc_i | input | PS_W | Second factor of the transfer period |
| frame_sync_o | output | 1 | High during the settle tick of each frame |
| slow_tick_o | output | 1 | First fast cycle of each slow tick |
| mux_state_o | output | IDX_W | Current multiplexer input index |
| conv_done_o | output | 1 | Conversion-complete strobe |
| conv_idx_o | output | IDX_W | Index of the conversion that just completed |
| pass_start_o | output | 1 | Compute-pass start strobe |
| rtm_start_o | output | 1 | Real-time stream start strobe |
| ssi_start_o | output | 1 | Bulk serial stream start strobe |
| rtm_busy_o | output | 1 | Real-time stream busy window |
| xfer_mark_o | output | 1 | Periodic transfer marker |

## Verification
Every output comes from a flop that is loaded at the same clock edge as the sequencer state it reflects. A strobe therefore appears in the first fast cycle of the slow tick it marks, with no further delay. The bench keeps a behavioural model that steps once per rising edge, tracking the position within the frame and the number of passes. It compares all outputs on the following falling edge, so a result that is early or late by one cycle fails. Configuration changes are applied in the middle of a frame, so the one-frame delay before they take effect is visible in the compared sync and multiplexer timing.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic {
    FLEN_SHORT = 1'b0,
    FLEN_LONG  = 1'b1
  } flen_e;

  // index of the final slow tick inside one conversion
  function automatic logic [1:0] conv_last_phase(input flen_e sel);
    return (sel == FLEN_LONG) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/mfs_tick_div.sv
module mfs_tick_div #(
  parameter int TICK_DIV = 150,
  localparam int DIV_W   = $clog2(TICK_DIV)
) (
  input  logic clk,
  input  logic rst,
  output logic tick_end_o,
  output logic slow_tick_o
);

  logic [DIV_W-1:0] div_q;

  assign tick_end_o = (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= '0;
      slow_tick_o <= 1'b0;
    end else begin
      div_q       <= tick_end_o ? '0 : div_q + 1'b1;
      slow_tick_o <= tick_end_o;
    end
  end

  assert_div_range_R1: assert property (@(posedge clk) disable iff (rst)
    div_q < DIV_W'(TICK_DIV));

  assert_tick_start_R1: assert property (@(posedge clk) disable iff (rst)
    slow_tick_o |-> (div_q == '0));

endmodule

// File: rtl/mfs_frame_ctl.sv
module mfs_frame_ctl
  import mfs_pkg::*;
#(
  parameter int MAX_STATES = 8,
  localparam int IDX_W     = $clog2(MAX_STATES),
  localparam int NCFG_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_end_i,
  input  logic [NCFG_W-1:0] cfg_nstates_i,
  input  logic              cfg_flen_i,
  output logic              settle_o,
  output logic [IDX_W-1:0]  mux_state_o,
  output logic              conv_done_o,
  output logic [IDX_W-1:0]  conv_idx_o,
  output logic              rise_now_o,
  output logic              fall_now_o
);

  logic [IDX_W-1:0] n_last_q;
  flen_e            flen_q;
  logic [1:0]       phase_q;
  logic             conv_end;

  function automatic logic [IDX_W-1:0] last_index(input logic [NCFG_W-1:0] req);
    if (req == '0)                           return '0;
    else if (req > NCFG_W'(MAX_STATES))      return IDX_W'(MAX_STATES - 1);
    else                                     return IDX_W'(req - 1'b1);
  endfunction

  assign conv_end   = tick_end_i && !settle_o && (phase_q == conv_last_phase(flen_q));
  assign rise_now_o = conv_end && (mux_state_o == n_last_q);
  assign fall_now_o = tick_end_i && settle_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_o    <= 1'b1;
      phase_q     <= '0;
      mux_state_o <= '0;
      conv_done_o <= 1'b0;
      conv_idx_o  <= '0;
      n_last_q    <= last_index(cfg_nstates_i);
      flen_q      <= flen_e'(cfg_flen_i);
    end else begin
      conv_done_o <= 1'b0;
      if (fall_now_o) begin
        settle_o <= 1'b0;
        phase_q  <= '0;
      end else if (conv_end) begin
        phase_q     <= '0;
        conv_done_o <= 1'b1;
        conv_idx_o  <= mux_state_o;
        if (rise_now_o) begin
          mux_state_o <= '0;
          settle_o    <= 1'b1;
          n_last_q    <= last_index(cfg_nstates_i);
          flen_q      <= flen_e'(cfg_flen_i);
        end else begin
          mux_state_o <= mux_state_o + 1'b1;
        end
      end else if (tick_end_i && !settle_o) begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    mux_state_o <= n_last_q);

  assert_done_idx_R3: assert property (@(posedge clk) disable iff (rst)
    conv_done_o |-> (conv_idx_o == $past(mux_state_o)));

  assert_settle_idx_R4: assert property (@(posedge clk) disable iff (rst)
    settle_o |-> (mux_state_o == '0));

endmodule

// File: rtl/mfs_pass_ctl.sv
module mfs_pass_ctl #(
  parameter int RTM_LEN = 140,
  parameter int PS_W    = 4,
  localparam int PROD_W = 2 * PS_W,
  localparam int RTM_W  = $clog2(RTM_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_now_i,
  input  logic            fall_now_i,
  input  logic [PS_W-1:0] cfg_presamps_i,
  input  logic [PS_W-1:0] cfg_sumcyc_i,
  output logic            pass_start_o,
  output logic            rtm_start_o,
  output logic            ssi_start_o,
  output logic            rtm_busy_o,
  output logic            xfer_mark_o
);

  logic [PROD_W-1:0] period_q;
  logic [PROD_W-1:0] pass_cnt_q;
  logic [PROD_W:0]   pass_cnt_inc;
  logic [RTM_W-1:0]  rtm_left_q;
  logic              period_hit;

  assign pass_cnt_inc = {1'b0, pass_cnt_q} + 1'b1;
  assign period_hit   = pass_cnt_inc >= {1'b0, period_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q     <= PROD_W'(cfg_presamps_i) * PROD_W'(cfg_sumcyc_i);
      pass_cnt_q   <= '0;
      pass_start_o <= 1'b0;
      xfer_mark_o  <= 1'b0;
      rtm_start_o  <= 1'b0;
      ssi_start_o  <= 1'b0;
      rtm_busy_o   <= 1'b0;
      rtm_left_q   <= '0;
    end else begin
      pass_start_o <= fall_now_i;
      rtm_start_o  <= rise_now_i;
      ssi_start_o  <= rise_now_i;
      xfer_mark_o  <= 1'b0;
      if (rise_now_i)
        period_q <= PROD_W'(cfg_presamps_i) * PROD_W'(cfg_sumcyc_i);
      if (fall_now_i) begin
        if (period_hit) begin
          xfer_mark_o <= 1'b1;
          pass_cnt_q  <= '0;
        end else begin
          pass_cnt_q  <= pass_cnt_inc[PROD_W-1:0];
        end
      end
      if (rise_now_i) begin
        rtm_busy_o <= 1'b1;
        rtm_left_q <= RTM_W'(RTM_LEN - 1);
      end else if (rtm_busy_o) begin
        if (rtm_left_q == '0) rtm_busy_o <= 1'b0;
        else                  rtm_left_q <= rtm_left_q - 1'b1;
      end
    end
  end

  assert_xfer_with_pass_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_mark_o |-> pass_start_o);

  assert_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !(rtm_busy_o && pass_start_o));

  assert_busy_opens_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rtm_busy_o) |-> rtm_start_o);

endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq #(
  parameter int TICK_DIV   = 150,
  parameter int MAX_STATES = 8,
  parameter int RTM_LEN    = 140,
  parameter int PS_W       = 4,
  localparam int IDX_W     = $clog2(MAX_STATES),
  localparam int NCFG_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCFG_W-1:0] cfg_nstates_i,
  input  logic              cfg_flen_i,
  input  logic [PS_W-1:0]   cfg_presamps_i,
  input  logic [PS_W-1:0]   cfg_sumcyc_i,
  output logic              frame_sync_o,
  output logic              slow_tick_o,
  output logic [IDX_W-1:0]  mux_state_o,
  output logic              conv_done_o,
  output logic [IDX_W-1:0]  conv_idx_o,
  output logic              pass_start_o,
  output logic              rtm_start_o,
  output logic              ssi_start_o,
  output logic              rtm_busy_o,
  output logic              xfer_mark_o
);

  logic tick_end;
  logic rise_now;
  logic fall_now;

  mfs_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk         (clk),
    .rst         (rst),
    .tick_end_o  (tick_end),
    .slow_tick_o (slow_tick_o)
  );

  mfs_frame_ctl #(.MAX_STATES(MAX_STATES)) u_frame (
    .clk           (clk),
    .rst           (rst),
    .tick_end_i    (tick_end),
    .cfg_nstates_i (cfg_nstates_i),
    .cfg_flen_i    (cfg_flen_i),
    .settle_o      (frame_sync_o),
    .mux_state_o   (mux_state_o),
    .conv_done_o   (conv_done_o),
    .conv_idx_o    (conv_idx_o),
    .rise_now_o    (rise_now),
    .fall_now_o    (fall_now)
  );

  mfs_pass_ctl #(.RTM_LEN(RTM_LEN), .PS_W(PS_W)) u_pass (
    .clk            (clk),
    .rst            (rst),
    .rise_now_i     (rise_now),
    .fall_now_i     (fall_now),
    .cfg_presamps_i (cfg_presamps_i),
    .cfg_sumcyc_i   (cfg_sumcyc_i),
    .pass_start_o   (pass_start_o),
    .rtm_start_o    (rtm_start_o),
    .ssi_start_o    (ssi_start_o),
    .rtm_busy_o     (rtm_busy_o),
    .xfer_mark_o    (xfer_mark_o)
  );

  assert_fall_pass_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_sync_o) |-> pass_start_o);

  assert_rise_streams_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_sync_o) |-> (rtm_start_o && ssi_start_o));

  assert_done_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    conv_done_o |-> slow_tick_o);

endmodule

// File: tb/mux_frame_seq_tb.sv
`timescale 1ns/1ps
module mux_frame_seq_tb_top;

  localparam int TD   = 150;
  localparam int MAXS = 8;
  localparam int RTML = 140;
  localparam int PSW  = 4;
  localparam int IW   = $clog2(MAXS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW:0]    cfg_n  = 4;
  logic           cfg_fl = 1'b1;
  logic [PSW-1:0] cfg_ps = 2;
  logic [PSW-1:0] cfg_sc = 1;

  logic frame_sync, slow_tick, conv_done, pass_start, rtm_start, ssi_start, rtm_busy, xfer_mark;
  logic [IW-1:0] mux_state, conv_idx;

  always #5 clk = ~clk;

  mux_frame_seq #(.TICK_DIV(TD), .MAX_STATES(MAXS), .RTM_LEN(RTML), .PS_W(PSW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_nstates_i(cfg_n), .cfg_flen_i(cfg_fl),
    .cfg_presamps_i(cfg_ps), .cfg_sumcyc_i(cfg_sc),
    .frame_sync_o(frame_sync), .slow_tick_o(slow_tick), .mux_state_o(mux_state),
    .conv_done_o(conv_done), .conv_idx_o(conv_idx), .pass_start_o(pass_start),
    .rtm_start_o(rtm_start), .ssi_start_o(ssi_start), .rtm_busy_o(rtm_busy),
    .xfer_mark_o(xfer_mark)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference state
  int f, n, L, nprev, M, pc;
  bit first, xf, model_ok = 0;
  int e_sync, e_tick, e_mux, e_done, e_idx, e_pass, e_start, e_busy, e_xfer;

  function automatic int clampn(input int v);
    if (v == 0) return 1;
    if (v > MAXS) return MAXS;
    return v;
  endfunction

  task automatic latch_cfg();
    n = clampn(int'(cfg_n));
    L = cfg_fl ? 3 : 2;
    M = int'(cfg_ps) * int'(cfg_sc);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      f = 0; pc = 0; first = 1; xf = 0;
      latch_cfg();
      nprev = n;
      model_ok = 1;
    end else if (model_ok) begin
      f++;
      if (f == (1 + L * n) * TD) begin
        f = 0; first = 0; nprev = n;
        latch_cfg();
      end
      xf = 0;
      if (f == TD) begin
        pc++;
        if (pc >= M) begin xf = 1; pc = 0; end
      end
    end
    if (model_ok) begin
      e_sync  = (f < TD) ? 1 : 0;
      e_tick  = ((f % TD) == 0 && !(first && f == 0)) ? 1 : 0;
      e_mux   = (f < TD) ? 0 : (f - TD) / (TD * L);
      e_done  = ((f == 0 && !first) || (f > TD && ((f - TD) % (TD * L)) == 0)) ? 1 : 0;
      e_idx   = (f == 0) ? nprev - 1 : (f - TD) / (TD * L) - 1;
      e_pass  = (f == TD) ? 1 : 0;
      e_start = (f == 0 && !first) ? 1 : 0;
      e_busy  = (f < RTML && !first) ? 1 : 0;
      e_xfer  = xf ? 1 : 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (model_ok && !rst && !done) begin
      chk("R2 R5", "frame_sync", int'(frame_sync), e_sync);
      chk("R1", "slow_tick", int'(slow_tick), e_tick);
      chk("R4 R5", "mux_state", int'(mux_state), e_mux);
      chk("R3", "conv_done", int'(conv_done), e_done);
      if (e_done == 1) chk("R3", "conv_idx", int'(conv_idx), e_idx);
      chk("R6", "pass_start", int'(pass_start), e_pass);
      chk("R7", "rtm_start", int'(rtm_start), e_start);
      chk("R7", "ssi_start", int'(ssi_start), e_start);
      chk("R8", "rtm_busy", int'(rtm_busy), e_busy);
      chk("R9", "xfer_mark", int'(xfer_mark), e_xfer);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic wait_cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic reset_check();
    // R10: state right after reset, taken before the next edge
    chk("R10", "sync after reset", int'(frame_sync), 1);
    chk("R10", "mux after reset", int'(mux_state), 0);
    chk("R10", "strobes after reset",
        int'({slow_tick, conv_done, pass_start, rtm_start, ssi_start, rtm_busy, xfer_mark}), 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    reset_check();
    // 4 states, 3-tick conversions, transfer every 2 passes (R3 450/900/1350/1800 pattern)
    wait_cycles(3 * 1950 + 700);
    // mid-frame change: 3 states, 2-tick, period 6 (R5 one-frame delay)
    cfg_n = 3; cfg_fl = 1'b0; cfg_ps = 3; cfg_sc = 2;
    wait_cycles(8 * 1050 + 300);
    // count 0 acts as 1, period 0 acts as 1 (R5, R9)
    cfg_n = 0; cfg_fl = 1'b1; cfg_ps = 0; cfg_sc = 5;
    wait_cycles(4000);
    // count above maximum clamps to 8 (R5)
    cfg_n = 15; cfg_ps = 1; cfg_sc = 1;
    wait_cycles(8000);
    cfg_n = 8; cfg_fl = 1'b0; cfg_ps = 2; cfg_sc = 2;
    wait_cycles(6000);
    // reset in the middle of a frame, new shape from the reset cycle
    rst = 1'b1;
    cfg_n = 2; cfg_fl = 1'b1; cfg_ps = 1; cfg_sc = 3;
    wait_cycles(2);
    rst = 1'b0;
    reset_check();
    wait_cycles(4000);
    finish_run();
  end

endmodule